// File: doc/BRIEF.md
# Level-Shifted Multicarrier Sine PWM Gate Generator

This block drives the gates of a single-phase multilevel inverter built with a reduced switch count. It produces a digital sine reference and compares it against a stack of triangular carriers. The carriers sit one above the other in equal amplitude bands, and the number of carriers the reference exceeds sets the output level. That level then selects one of several magnitude switches and one of two diagonal polarity pairs.

All carriers come from one shared up/down ramp counter. A run-time mode input chooses which bands use the inverted ramp. This gives three dispositions: all bands in phase; bands below zero in antiphase with bands above; or neighbouring bands alternating.

The reference is a quarter-wave sine table read through a phase index. The index is stepped with an exact fractional accumulator, so one reference cycle always spans a whole number of carrier periods. A signed Q1.15 modulation index scales the reference. The parameter `LEVELS` is the odd number of output levels, and the default is 5.

Top module: `slspwm_gen`

## Requirements
- R1: With NB = LEVELS−1 bands, H = NB/2, STEP = 65536/(NB·CAR_STEPS) and BAND = STEP·CAR_STEPS, band k (0 ≤ k < NB) carries the value (k−H)·BAND + p·STEP. Here p is the ramp value r, or CAR_STEPS−r when the band is inverted.
- R2: The ramp starts at 0 after enable and rises by one per carrier step up to CAR_STEPS, then falls back to 0, so one period is 2·CAR_STEPS steps. At step n the reference index is floor(1024·n/P) mod 1024, where P = ratio·2·CAR_STEPS and ratio ≥ 8.
- R3: Mode code 2'b00 inverts no band.
- R4: Mode code 2'b01 inverts exactly the bands with k < H, which are the bands below zero.
- R5: Mode code 2'b10 inverts the bands with odd k. Code 2'b11 behaves like 2'b00.
- R6: For reference index i, the reference equals floor(S(i)·mi/32768). S(i) approximates 32767·sin((i+0.5)·π/512) to within 64, and the result is clamped to ±H·BAND.
- R7: The signed level equals the number of bands whose value is strictly below the reference, minus H.
- R8: `gate_lvl` is one-hot, with bit |level| set.
- R9: A positive level drives gate_pos = 2'b11 and gate_neg = 2'b00. A negative level drives the reverse. Level 0 keeps the previous polarity, and positive polarity applies after reset or disable.
- R10: A new mode value is adopted only on a carrier step where bit 9 of the reference index changes, or while the block is disabled.
- R11: With rst_n or en low at a clock edge, all gate outputs are 0 after that edge. Enabling again restarts from step 0.
- R12: One carrier step occurs every step_div+1 clocks. The gates after enabled edge k reflect step floor((k−1)/(step_div+1)).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Run enable; low forces gates off and restarts timing |
| mode | input | 2 | Carrier disposition code |
| mi_scale | input | 16 | Signed Q1.15 modulation index |
| step_div | input | DIV_W | Clocks per carrier step minus one |
| ratio | input | RAT_W | Carrier periods per reference cycle (at least 8) |
| gate_pos | output | 2 | Diagonal pair giving positive output |
| gate_neg | output | 2 | Diagonal pair giving negative output |
| gate_lvl | output | LEVELS/2+1 | One-hot magnitude switches, bit 0 = zero output |

## Verification
Two things can land on the same carrier step: a mode request that is still pending and a half-cycle crossing of the reference index. On that step the new disposition must take over exactly, neither a step early nor a step late. The bench changes the mode code well before a crossing and compares each step against a model that switches dispositions only at the crossing step, so an early or late switch shows up as level mismatches. A second overlap is level zero arriving together with a polarity that must be held. This is judged at zero modulation index, where the reference sits exactly on band edges.

// File: rtl/slspwm_pkg.sv
// Shared types and constants for the level-shifted PWM generator.
// Assumes a 1024-step reference cycle built from a 256-entry quarter table.
package slspwm_pkg;

    typedef enum logic [1:0] {
        DISP_SAME = 2'b00,   // all bands in phase
        DISP_SPLT = 2'b01,   // bands below zero inverted
        DISP_ALT  = 2'b10,   // odd bands inverted
        DISP_RSVD = 2'b11    // treated as DISP_SAME
    } disp_mode_e;

    localparam int IDX_W  = 10;
    localparam int ROM_N  = 256;
    localparam int SIN_FS = 32767;

    // Quarter-wave sample at half-step offset, rational sine approximation.
    function automatic logic signed [15:0] quarter_sine(input int a);
        longint u, prod, den, val;
        u    = longint'(2 * a + 1);
        prod = u * (longint'(1024) - u);
        den  = longint'(5 * 1048576) - 4 * prod;
        val  = (longint'(SIN_FS) * 16 * prod) / den;
        return 16'(val);
    endfunction

endpackage

// File: rtl/slspwm_timebase.sv
// Carrier ramp, reference phase index and mode latch.
// Assumes ratio*2*CAR_STEPS >= 256 so the index advances at most 4 per step.
module slspwm_timebase
    import slspwm_pkg::*;
#(
    parameter int CAR_STEPS = 16,
    parameter int DIV_W     = 16,
    parameter int RAT_W     = 8,
    localparam int RAMP_W   = $clog2(CAR_STEPS + 1),
    localparam int PER_W    = RAT_W + $clog2(2 * CAR_STEPS) + 1,
    localparam int ERR_W    = ((PER_W > 11) ? PER_W : 11) + 1,
    localparam int MAX_ADV  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [1:0]        mode_in,
    input  logic [DIV_W-1:0]  step_div,
    input  logic [RAT_W-1:0]  ratio,
    output logic [RAMP_W-1:0] ramp,
    output logic [IDX_W-1:0]  ref_idx,
    output disp_mode_e        mode_act
);

    logic [DIV_W-1:0]  div_q;
    logic              tick;
    logic              dir_up;
    logic [RAMP_W-1:0] ramp_q;
    logic [ERR_W-1:0]  err_q, err_sum;
    logic [IDX_W-1:0]  idx_q, idx_nxt;
    logic [2:0]        adv;
    logic [PER_W-1:0]  period;
    logic              half_flip;
    disp_mode_e        mode_q;

    assign tick   = (div_q == step_div);
    assign period = PER_W'(ratio) * PER_W'(2 * CAR_STEPS);

    // Clock prescaler producing one carrier-step tick.
    always_ff @(posedge clk) begin
        if (!rst_n || !en)  div_q <= '0;
        else if (tick)      div_q <= '0;
        else                div_q <= div_q + 1'b1;
    end

    // Triangular ramp 0..CAR_STEPS..0 shared by every band.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            ramp_q <= '0;
            dir_up <= 1'b1;
        end else if (tick) begin
            if (dir_up) begin
                if (ramp_q == RAMP_W'(CAR_STEPS - 1)) dir_up <= 1'b0;
                ramp_q <= ramp_q + 1'b1;
            end else begin
                if (ramp_q == RAMP_W'(1)) dir_up <= 1'b1;
                ramp_q <= ramp_q - 1'b1;
            end
        end
    end

    // Exact fractional stepping: 1024 index units per P carrier steps.
    always_comb begin
        err_sum = err_q + ERR_W'(1024);
        adv     = '0;
        for (int i = 0; i < MAX_ADV; i++) begin
            if (err_sum >= ERR_W'(period)) begin
                err_sum = err_sum - ERR_W'(period);
                adv     = adv + 1'b1;
            end
        end
        idx_nxt = idx_q + IDX_W'(adv);
    end

    assign half_flip = idx_nxt[IDX_W-1] ^ idx_q[IDX_W-1];

    // Phase index and remainder registers.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            err_q <= '0;
            idx_q <= '0;
        end else if (tick) begin
            err_q <= err_sum;
            idx_q <= idx_nxt;
        end
    end

    // Mode latch: follows input while idle, else only at half-cycle crossings.
    always_ff @(posedge clk) begin
        if (!rst_n)                  mode_q <= DISP_SAME;
        else if (!en)                mode_q <= disp_mode_e'(mode_in);
        else if (tick && half_flip)  mode_q <= disp_mode_e'(mode_in);
    end

    assign ramp     = ramp_q;
    assign ref_idx  = idx_q;
    assign mode_act = mode_q;

    // R10
    mode_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && !(tick && half_flip)) |=> $stable(mode_q));

    // R2
    ramp_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && tick) |=> ((ramp_q == $past(ramp_q) + 1'b1) || (ramp_q == $past(ramp_q) - 1'b1)));

endmodule

// File: rtl/slspwm_reference.sv
// Scaled sine reference: quarter table, quadrant mirroring, Q1.15 multiply, clamp.
// Assumes LIMIT fits in CMP_W-1 magnitude bits.
module slspwm_reference
    import slspwm_pkg::*;
#(
    parameter int CMP_W = 18,
    parameter int LIMIT = 32768
) (
    input  logic [IDX_W-1:0]        ref_idx,
    input  logic signed [15:0]      mi_scale,
    output logic signed [CMP_W-1:0] ref_val
);

    logic signed [15:0] rom [ROM_N];
    logic [7:0]         addr;
    logic signed [32:0] samp_x, mi_x, prod, scaled;

    // Table contents computed at elaboration.
    for (genvar g = 0; g < ROM_N; g++) begin : g_rom
        assign rom[g] = quarter_sine(g);
    end

    // Quadrant mirroring, scaling and clamping of the reference.
    always_comb begin
        addr   = ref_idx[8] ? ~ref_idx[7:0] : ref_idx[7:0];
        samp_x = 33'(rom[addr]);
        if (ref_idx[9]) samp_x = -samp_x;
        mi_x   = 33'(mi_scale);
        prod   = samp_x * mi_x;
        scaled = prod >>> 15;
        if (scaled > 33'(LIMIT))        ref_val = CMP_W'(LIMIT);
        else if (scaled < -33'(LIMIT))  ref_val = -CMP_W'(LIMIT);
        else                            ref_val = CMP_W'(scaled);
    end

endmodule

// File: rtl/slspwm_compare.sv
// Stacked carrier bands built from one ramp, compared against the reference.
// Assumes LEVELS is odd and at least 3.
module slspwm_compare
    import slspwm_pkg::*;
#(
    parameter int LEVELS    = 5,
    parameter int CAR_STEPS = 16,
    parameter int CMP_W     = 18,
    localparam int NB       = LEVELS - 1,
    localparam int HALF     = NB / 2,
    localparam int STEP     = 65536 / (NB * CAR_STEPS),
    localparam int BAND     = STEP * CAR_STEPS,
    localparam int RAMP_W   = $clog2(CAR_STEPS + 1),
    localparam int CNT_W    = $clog2(NB + 1),
    localparam int LVL_W    = CNT_W + 1
) (
    input  logic signed [CMP_W-1:0] ref_val,
    input  logic [RAMP_W-1:0]       ramp,
    input  disp_mode_e              mode_act,
    output logic signed [LVL_W-1:0] level
);

    logic [NB-1:0]    above;
    logic [CNT_W-1:0] cnt;

    for (genvar k = 0; k < NB; k++) begin : g_band
        localparam int BASE = (k - HALF) * BAND;
        logic                    inv;
        logic [RAMP_W-1:0]       pos;
        logic signed [CMP_W-1:0] car;

        // Band phase selection by disposition mode.
        always_comb begin
            case (mode_act)
                DISP_SPLT: inv = 1'((k < HALF) ? 1 : 0);
                DISP_ALT:  inv = 1'(k % 2);
                default:   inv = 1'b0;
            endcase
        end

        assign pos      = inv ? (RAMP_W'(CAR_STEPS) - ramp) : ramp;
        assign car      = CMP_W'(BASE + int'(pos) * STEP);
        assign above[k] = (ref_val > car);
    end

    // Count of bands under the reference, centred to a signed level.
    always_comb begin
        cnt = '0;
        for (int k = 0; k < NB; k++) cnt = cnt + CNT_W'(above[k]);
        level = LVL_W'(cnt) - LVL_W'(HALF);
    end

endmodule

// File: rtl/slspwm_gate_decode.sv
// Registers the gate pattern: polarity pairs from the level sign, one-hot magnitude.
// Assumes level lies within -HALF..HALF.
module slspwm_gate_decode #(
    parameter int LEVELS  = 5,
    localparam int HALF   = (LEVELS - 1) / 2,
    localparam int LVL_W  = $clog2(LEVELS) + 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    en,
    input  logic signed [LVL_W-1:0] level,
    output logic [1:0]              gate_pos,
    output logic [1:0]              gate_neg,
    output logic [HALF:0]           gate_lvl
);

    logic             pol_q, pol_nxt;
    logic [LVL_W-1:0] mag;
    logic [HALF:0]    lvl_nxt;

    // Polarity choice and one-hot magnitude for the next pattern.
    always_comb begin
        if (level > 0)       pol_nxt = 1'b1;
        else if (level < 0)  pol_nxt = 1'b0;
        else                 pol_nxt = pol_q;
        mag = (level < 0) ? LVL_W'(-level) : LVL_W'(level);
        for (int i = 0; i <= HALF; i++) lvl_nxt[i] = (mag == LVL_W'(i));
    end

    // Gate output and polarity registers; all off while idle.
    always_ff @(posedge clk) begin
        if (!rst_n || !en) begin
            pol_q    <= 1'b1;
            gate_pos <= '0;
            gate_neg <= '0;
            gate_lvl <= '0;
        end else begin
            pol_q    <= pol_nxt;
            gate_pos <= {2{pol_nxt}};
            gate_neg <= {2{~pol_nxt}};
            gate_lvl <= lvl_nxt;
        end
    end

    // R11
    off_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (gate_pos == 2'b00 && gate_neg == 2'b00 && gate_lvl == '0));

    // R8
    lvl_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> $onehot(gate_lvl));

    // R9
    pol_compl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        en |=> (gate_pos == ~gate_neg));

    // R9
    pol_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && level == 0 && gate_pos == 2'b11) |=> (gate_pos == 2'b11));

endmodule

// File: rtl/slspwm_gen.sv
// Top: level-shifted multicarrier sine PWM gate generator.
// Assumes odd LEVELS >= 3, CAR_STEPS >= 2 and ratio >= 8 at run time.
module slspwm_gen
    import slspwm_pkg::*;
#(
    parameter int LEVELS    = 5,
    parameter int CAR_STEPS = 16,
    parameter int DIV_W     = 16,
    parameter int RAT_W     = 8,
    localparam int NB       = LEVELS - 1,
    localparam int HALF     = NB / 2,
    localparam int STEP     = 65536 / (NB * CAR_STEPS),
    localparam int LIMIT    = HALF * STEP * CAR_STEPS,
    localparam int CMP_W    = 18,
    localparam int RAMP_W   = $clog2(CAR_STEPS + 1),
    localparam int LVL_W    = $clog2(NB + 1) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic [1:0]        mode,
    input  logic [15:0]       mi_scale,
    input  logic [DIV_W-1:0]  step_div,
    input  logic [RAT_W-1:0]  ratio,
    output logic [1:0]        gate_pos,
    output logic [1:0]        gate_neg,
    output logic [HALF:0]     gate_lvl
);

    logic [RAMP_W-1:0]       ramp;
    logic [IDX_W-1:0]        ref_idx;
    disp_mode_e              mode_act;
    logic signed [CMP_W-1:0] ref_val;
    logic signed [LVL_W-1:0] level;

    slspwm_timebase #(
        .CAR_STEPS (CAR_STEPS),
        .DIV_W     (DIV_W),
        .RAT_W     (RAT_W)
    ) u_tb (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .mode_in  (mode),
        .step_div (step_div),
        .ratio    (ratio),
        .ramp     (ramp),
        .ref_idx  (ref_idx),
        .mode_act (mode_act)
    );

    slspwm_reference #(
        .CMP_W (CMP_W),
        .LIMIT (LIMIT)
    ) u_ref (
        .ref_idx  (ref_idx),
        .mi_scale (mi_scale),
        .ref_val  (ref_val)
    );

    slspwm_compare #(
        .LEVELS    (LEVELS),
        .CAR_STEPS (CAR_STEPS),
        .CMP_W     (CMP_W)
    ) u_cmp (
        .ref_val  (ref_val),
        .ramp     (ramp),
        .mode_act (mode_act),
        .level    (level)
    );

    slspwm_gate_decode #(
        .LEVELS (LEVELS)
    ) u_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .level    (level),
        .gate_pos (gate_pos),
        .gate_neg (gate_neg),
        .gate_lvl (gate_lvl)
    );

endmodule

// File: tb/tb_slspwm_gen.sv
`timescale 1ns/1ps
// Self-checking bench: a vector table of runs against a step-level model,
// then directed reset and disable cases.
module tb_slspwm_gen;

    localparam int CS    = 16;
    localparam int NB    = 4;
    localparam int HB    = 2;
    localparam int STP   = 1024;
    localparam int BANDV = 16384;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        en = 1'b1;
    logic [1:0]  mode_in = 2'b00;
    logic [15:0] mi_scale = 16'd0;
    logic [15:0] step_div = 16'd0;
    logic [7:0]  ratio = 8'd8;
    logic [1:0]  gate_pos, gate_neg;
    logic [2:0]  gate_lvl;

    int n_tests = 0;
    int n_fail  = 0;

    always #5 clk = ~clk;

    slspwm_gen dut (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (en),
        .mode     (mode_in),
        .mi_scale (mi_scale),
        .step_div (step_div),
        .ratio    (ratio),
        .gate_pos (gate_pos),
        .gate_neg (gate_neg),
        .gate_lvl (gate_lvl)
    );

    // fields: mode_a, mode_b, switch_k, mi, ratio, step_div, steps
    localparam int NV = 9;
    localparam int VEC [NV][7] = '{
        '{0, 0, -1,  32767, 20, 0, 640},   // R3 all in phase
        '{1, 1, -1,  32767, 20, 0, 640},   // R4 split about zero
        '{2, 2, -1,  32767, 20, 0, 640},   // R5 alternating
        '{3, 3, -1,  32767,  8, 0, 256},   // R5 reserved code acts as 00
        '{0, 0, -1,  16384,  8, 1, 256},   // R12 prescaled steps
        '{2, 2, -1, -16384, 12, 0, 384},   // R6 negative index
        '{1, 1, -1,  24576,  8, 3, 128},   // R12 slow steps
        '{2, 2, -1,      0,  8, 0,  64},   // R7 R9 reference on band edges
        '{0, 2, 40,  32767,  8, 0, 256}    // R10 pending mode change
    };

    task automatic check(input bit ok, input string what, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
        end
    endtask

    function automatic int norm_mode(input int m);
        return (m == 3) ? 0 : m;
    endfunction

    // R2: reference index after n steps.
    function automatic int idx_of(input int n, input int rat);
        return int'((longint'(n) * 1024 / longint'(rat * 2 * CS)) % 1024);
    endfunction

    // R2: ramp value after n steps.
    function automatic int ramp_of(input int n);
        int r;
        r = n % (2 * CS);
        return (r <= CS) ? r : (2 * CS - r);
    endfunction

    // R1 R3 R4 R5: band value.
    function automatic int car_of(input int k, input int t, input int m);
        bit inv;
        inv = (m == 1) ? (k < HB) : (m == 2) ? (k % 2 == 1) : 1'b0;
        return (k - HB) * BANDV + (inv ? (CS - t) : t) * STP;
    endfunction

    // R6: ideal reference.
    function automatic real ref_of(input int idx, input int mi);
        real s;
        s = 32767.0 * $sin((real'(idx) + 0.5) * 3.14159265358979 / 512.0);
        return $floor(s * real'(mi) / 32768.0);
    endfunction

    task automatic run(input int ma, input int mb, input int sw_k, input int mi,
                       input int rat, input int d, input int nsteps, input string tag);
        int mcur, n, cnt, lvl_exp, mag, c;
        bit amb, pol, pol_known;
        real r;
        en       = 1'b0;
        mode_in  = 2'(ma);
        mi_scale = 16'(mi);
        ratio    = 8'(rat);
        step_div = 16'(d);
        @(negedge clk);
        @(negedge clk);
        en        = 1'b1;
        mcur      = norm_mode(ma);
        pol       = 1'b1;
        pol_known = 1'b1;
        for (int k = 1; k <= nsteps * (d + 1); k++) begin
            @(negedge clk);
            n = (k - 1) / (d + 1);
            if (n >= 1 && ((k - 1) % (d + 1)) == 0) begin
                if ((idx_of(n, rat) / 512) != (idx_of(n - 1, rat) / 512))
                    mcur = norm_mode((n * (d + 1) > sw_k) ? mb : ma);
            end
            r   = ref_of(idx_of(n, rat), mi);
            cnt = 0;
            amb = 1'b0;
            for (int b = 0; b < NB; b++) begin
                c = car_of(b, ramp_of(n), mcur);
                if (r > real'(c)) cnt++;
                if (mi != 0 && (r - real'(c) < 256.0) && (real'(c) - r < 256.0)) amb = 1'b1;
            end
            lvl_exp = cnt - HB;
            if (!amb) begin
                if (lvl_exp > 0)      begin pol = 1'b1; pol_known = 1'b1; end
                else if (lvl_exp < 0) begin pol = 1'b0; pol_known = 1'b1; end
                mag = (lvl_exp < 0) ? -lvl_exp : lvl_exp;
                // R1 R2 R7 R8 R12
                check(gate_lvl == 3'(1 << mag),
                      $sformatf("R7 R8 %s step %0d lvl", tag, n), int'(gate_lvl), 1 << mag);
                if (pol_known)
                    check({gate_pos, gate_neg} == (pol ? 4'b1100 : 4'b0011),
                          $sformatf("R9 %s step %0d pol", tag, n),
                          int'({gate_pos, gate_neg}), pol ? 12 : 3);
            end else begin
                pol_known = 1'b0;
            end
            if (k == sw_k) mode_in = 2'(mb);
        end
        en = 1'b0;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R11: reset holds all gates low even with enable high.
        repeat (3) @(negedge clk);
        check({gate_pos, gate_neg, gate_lvl} == 7'd0, "R11 reset state",
              int'({gate_pos, gate_neg, gate_lvl}), 0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++)
            run(VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], VEC[v][6],
                $sformatf("vec%0d", v));

        // R11: disable mid-run clears gates at the next edge.
        mode_in = 2'b00; mi_scale = 16'd32767; ratio = 8'd8; step_div = 16'd0;
        en = 1'b1;
        repeat (70) @(negedge clk);
        check(gate_lvl != 3'd0, "R11 running before disable", int'(gate_lvl), 1);
        en = 1'b0;
        @(negedge clk);
        check({gate_pos, gate_neg, gate_lvl} == 7'd0, "R11 disable clears",
              int'({gate_pos, gate_neg, gate_lvl}), 0);

        // R11: synchronous reset mid-run clears gates.
        en = 1'b1;
        repeat (30) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check({gate_pos, gate_neg, gate_lvl} == 7'd0, "R11 reset mid-run",
              int'({gate_pos, gate_neg, gate_lvl}), 0);
        rst_n = 1'b1;
        en = 1'b0;

        // R11: after reset, a fresh run restarts from step 0.
        run(1, 1, -1, 32767, 8, 0, 64, "restart");

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule